// File: doc/BRIEF.md
# RV32I Subset Decode and Execute Stage

This block takes one 32-bit instruction word, the program counter it was fetched from, and the two source register values, and in a single registered step produces everything a simple processor needs to finish that instruction. The outputs are the register index fields, the sign-extended immediate, a class code, the arithmetic result (which doubles as the memory address for loads and stores), a branch decision, the branch or jump target and the link value. Only sixteen instructions are recognised. These are the register-register operations add, subtract, exclusive-or, or and and; their immediate counterparts; word load and word store; the four conditional branches equal, not-equal, signed less-than and signed greater-or-equal; and the jump-and-link.

Every other encoding is flagged as illegal, and no write enable is raised for it. The block holds no register file and no memory. The surrounding datapath reads the operands, presents them together with the instruction, and takes the results one clock later.

Top module: `insn_exec_unit`

## Requirements
- R1: While `rst_n` is low every output is zero. Otherwise every output, one cycle after a rising clock edge, reflects the inputs sampled at that edge.
- R2: Opcode 0110011 is class 1 with `reg_we`=1. funct3 000 with funct7 0000000 adds `op_a`+`op_b`, and funct3 000 with funct7 0100000 subtracts `op_a`-`op_b`. With funct7 0000000, funct3 100 gives XOR, 110 gives OR and 111 gives AND. The immediate is zero.
- R3: Opcode 0010011 is class 2 with `reg_we`=1. funct3 000, 100, 110 and 111 give add, XOR, OR and AND of `op_a` with the immediate. The immediate is bits [31:20] sign-extended, and funct7 is not examined.
- R4: Opcode 0000011 with funct3 010 is class 3 with `reg_we`=1 and `mem_re`=1. Its immediate is the I form, and `alu_res` is `op_a` plus that immediate.
- R5: Opcode 0100011 with funct3 010 is class 4 with `mem_we`=1 and `reg_we`=0. Its immediate is bits [31:25] above bits [11:7], sign-extended, and `alu_res` is `op_a` plus that immediate.
- R6: Opcode 1100011 is class 5 with no enables, and `alu_res` is `op_a`-`op_b`. funct3 000 takes the branch when the operands are equal and 001 takes it when they differ. `br_taken` is never 1 outside class 5.
- R7: In class 5, funct3 100 takes the branch when `op_a` < `op_b` and funct3 101 takes it when `op_a` >= `op_b`. Both compare the operands as signed two's-complement values.
- R8: The branch immediate is bit 31 as sign, then bit 7, bits [30:25], bits [11:8] and a zero LSB. `target` always equals `pc` plus the output immediate.
- R9: Opcode 1101111 is class 6 with `reg_we`=1, whatever funct3 holds. Its immediate is bit 31 as sign, then bits [19:12], bit 20, bits [30:21] and a zero LSB. `link` is always `pc`+4, and `alu_res` equals `link` in class 6.
- R10: Any other opcode/funct combination gives class 0 and `illegal`=1. It also gives zero immediate, zero `alu_res`, `br_taken`=0 and all three enables 0.
- R11: `rs1_idx`, `rs2_idx` and `rd_idx` are instruction bits [19:15], [24:20] and [11:7] for every instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| op_a | input | 32 | First source register value |
| op_b | input | 32 | Second source register value |
| rs1_idx | output | 5 | First source index |
| rs2_idx | output | 5 | Second source index |
| rd_idx | output | 5 | Destination index |
| imm | output | 32 | Sign-extended immediate |
| iclass | output | 3 | Class code (0 illegal, 1 reg, 2 imm, 3 load, 4 store, 5 branch, 6 jump) |
| alu_res | output | 32 | Arithmetic result or memory address |
| br_taken | output | 1 | Conditional branch taken |
| target | output | 32 | pc plus immediate |
| link | output | 32 | pc plus 4 |
| reg_we | output | 1 | Destination register write enable |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| illegal | output | 1 | Encoding outside the supported subset |

## Verification
The bench sweeps every opcode against all eight funct3 values and four funct7 patterns, with pseudo-random register fields and operands. This pattern separates legal encodings from illegal ones and catches a decoder that checks too few or too many funct bits. Directed branch operands that straddle the sign boundary (0x7fffffff against 0x80000000, and -1 against 1) tell a signed compare from an unsigned one. Equal and unequal pairs tell BEQ from BNE. Immediate fields filled with all ones, a lone sign bit, or a lone low bit show whether the scattered branch and jump fields have been put back in the right order and sign-extended.

// File: rtl/insn_exec_pkg.sv
package insn_exec_pkg;
  localparam int XLEN  = 32;
  localparam int ILEN  = 32;
  localparam int RIDX  = 5;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE = 3'd0, CLS_REG = 3'd1, CLS_IMM = 3'd2, CLS_LOAD = 3'd3,
    CLS_STORE = 3'd4, CLS_BRANCH = 3'd5, CLS_JUMP = 3'd6
  } iclass_e;

  typedef enum logic [2:0] {AOP_ADD, AOP_SUB, AOP_XOR, AOP_OR, AOP_AND} aop_e;
  typedef enum logic [1:0] {CMP_EQ, CMP_NE, CMP_LT, CMP_GE} cmp_e;
  typedef enum logic [2:0] {FMT_NONE, FMT_I, FMT_S, FMT_B, FMT_J} fmt_e;

  typedef struct packed {
    iclass_e cls;
    aop_e    aop;
    cmp_e    cmp;
    fmt_e    fmt;
    logic    use_imm;
    logic    reg_we;
    logic    mem_we;
    logic    mem_re;
    logic    illegal;
  } ctrl_t;

  function automatic logic [XLEN-1:0] imm_i(input logic [ILEN-1:0] w);
    return {{(XLEN-12){w[31]}}, w[31:20]};
  endfunction

  function automatic logic [XLEN-1:0] imm_s(input logic [ILEN-1:0] w);
    return {{(XLEN-12){w[31]}}, w[31:25], w[11:7]};
  endfunction

  function automatic logic [XLEN-1:0] imm_b(input logic [ILEN-1:0] w);
    return {{(XLEN-13){w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] imm_j(input logic [ILEN-1:0] w);
    return {{(XLEN-21){w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] alu_fn(input aop_e op,
                                             input logic [XLEN-1:0] a,
                                             input logic [XLEN-1:0] b);
    case (op)
      AOP_SUB: return a - b;
      AOP_XOR: return a ^ b;
      AOP_OR:  return a | b;
      AOP_AND: return a & b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic cmp_fn(input cmp_e op,
                                  input logic [XLEN-1:0] a,
                                  input logic [XLEN-1:0] b);
    case (op)
      CMP_EQ:  return a == b;
      CMP_NE:  return a != b;
      CMP_LT:  return $signed(a) < $signed(b);
      default: return $signed(a) >= $signed(b);
    endcase
  endfunction
endpackage

// File: rtl/insn_decode.sv
module insn_decode
  import insn_exec_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output ctrl_t           ctrl,
  output logic [XLEN-1:0] imm
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       bad;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];

  always_comb begin
    ctrl = '0;
    bad  = 1'b0;
    case (opc)
      7'b0110011: begin
        ctrl.cls    = CLS_REG;
        ctrl.reg_we = 1'b1;
        case (f3)
          3'b000: begin
            if (f7 == 7'b0000000)      ctrl.aop = AOP_ADD;
            else if (f7 == 7'b0100000) ctrl.aop = AOP_SUB;
            else                       bad = 1'b1;
          end
          3'b100: begin ctrl.aop = AOP_XOR; bad = (f7 != 7'b0); end
          3'b110: begin ctrl.aop = AOP_OR;  bad = (f7 != 7'b0); end
          3'b111: begin ctrl.aop = AOP_AND; bad = (f7 != 7'b0); end
          default: bad = 1'b1;
        endcase
      end
      7'b0010011: begin
        ctrl.cls     = CLS_IMM;
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.fmt     = FMT_I;
        case (f3)
          3'b000:  ctrl.aop = AOP_ADD;
          3'b100:  ctrl.aop = AOP_XOR;
          3'b110:  ctrl.aop = AOP_OR;
          3'b111:  ctrl.aop = AOP_AND;
          default: bad = 1'b1;
        endcase
      end
      7'b0000011: begin
        ctrl.cls     = CLS_LOAD;
        ctrl.reg_we  = 1'b1;
        ctrl.mem_re  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.fmt     = FMT_I;
        bad          = (f3 != 3'b010);
      end
      7'b0100011: begin
        ctrl.cls     = CLS_STORE;
        ctrl.mem_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.fmt     = FMT_S;
        bad          = (f3 != 3'b010);
      end
      7'b1100011: begin
        ctrl.cls = CLS_BRANCH;
        ctrl.aop = AOP_SUB;
        ctrl.fmt = FMT_B;
        case (f3)
          3'b000:  ctrl.cmp = CMP_EQ;
          3'b001:  ctrl.cmp = CMP_NE;
          3'b100:  ctrl.cmp = CMP_LT;
          3'b101:  ctrl.cmp = CMP_GE;
          default: bad = 1'b1;
        endcase
      end
      7'b1101111: begin
        ctrl.cls    = CLS_JUMP;
        ctrl.reg_we = 1'b1;
        ctrl.fmt    = FMT_J;
      end
      default: bad = 1'b1;
    endcase
    if (bad) begin
      ctrl         = '0;
      ctrl.illegal = 1'b1;
    end
  end

  always_comb begin
    case (ctrl.fmt)
      FMT_I:   imm = imm_i(instr);
      FMT_S:   imm = imm_s(instr);
      FMT_B:   imm = imm_b(instr);
      FMT_J:   imm = imm_j(instr);
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/insn_alu.sv
module insn_alu
  import insn_exec_pkg::*;
(
  input  aop_e            op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  assign y = alu_fn(op, a, b);
endmodule

// File: rtl/insn_brcmp.sv
module insn_brcmp
  import insn_exec_pkg::*;
(
  input  cmp_e            op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            hit
);
  assign hit = cmp_fn(op, a, b);
endmodule

// File: rtl/insn_exec_unit.sv
module insn_exec_unit
  import insn_exec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ILEN-1:0]  instr,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  op_a,
  input  logic [XLEN-1:0]  op_b,
  output logic [RIDX-1:0]  rs1_idx,
  output logic [RIDX-1:0]  rs2_idx,
  output logic [RIDX-1:0]  rd_idx,
  output logic [XLEN-1:0]  imm,
  output logic [CLS_W-1:0] iclass,
  output logic [XLEN-1:0]  alu_res,
  output logic             br_taken,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  link,
  output logic             reg_we,
  output logic             mem_we,
  output logic             mem_re,
  output logic             illegal
);
  localparam logic [XLEN-1:0] STEP = XLEN'(ILEN / 8);

  ctrl_t           ctrl_w;
  logic [XLEN-1:0] imm_w;
  logic [XLEN-1:0] opnd_b_w;
  logic [XLEN-1:0] alu_w;
  logic            cmp_hit_w;
  logic [XLEN-1:0] link_w;
  logic [XLEN-1:0] tgt_w;
  logic [XLEN-1:0] res_w;
  logic            taken_w;

  insn_decode u_dec (.instr(instr), .ctrl(ctrl_w), .imm(imm_w));

  assign opnd_b_w = ctrl_w.use_imm ? imm_w : op_b;

  insn_alu u_alu (.op(ctrl_w.aop), .a(op_a), .b(opnd_b_w), .y(alu_w));

  insn_brcmp u_cmp (.op(ctrl_w.cmp), .a(op_a), .b(op_b), .hit(cmp_hit_w));

  assign link_w  = pc + STEP;
  assign tgt_w   = pc + imm_w;
  assign taken_w = (ctrl_w.cls == CLS_BRANCH) && cmp_hit_w;

  always_comb begin
    if (ctrl_w.illegal)              res_w = '0;
    else if (ctrl_w.cls == CLS_JUMP) res_w = link_w;
    else                             res_w = alu_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_idx  <= '0;
      rs2_idx  <= '0;
      rd_idx   <= '0;
      imm      <= '0;
      iclass   <= '0;
      alu_res  <= '0;
      br_taken <= 1'b0;
      target   <= '0;
      link     <= '0;
      reg_we   <= 1'b0;
      mem_we   <= 1'b0;
      mem_re   <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      rs1_idx  <= instr[19:15];
      rs2_idx  <= instr[24:20];
      rd_idx   <= instr[11:7];
      imm      <= imm_w;
      iclass   <= ctrl_w.cls;
      alu_res  <= res_w;
      br_taken <= taken_w;
      target   <= tgt_w;
      link     <= link_w;
      reg_we   <= ctrl_w.reg_we;
      mem_we   <= ctrl_w.mem_we;
      mem_re   <= ctrl_w.mem_re;
      illegal  <= ctrl_w.illegal;
    end
  end
endmodule

// File: rtl/insn_exec_chk.sv
module insn_exec_chk
  import insn_exec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [ILEN-1:0]  instr,
  input logic [XLEN-1:0]  pc,
  input logic [XLEN-1:0]  op_a,
  input logic [XLEN-1:0]  op_b,
  input logic [RIDX-1:0]  rs1_idx,
  input logic [RIDX-1:0]  rs2_idx,
  input logic [RIDX-1:0]  rd_idx,
  input logic [XLEN-1:0]  imm,
  input logic [CLS_W-1:0] iclass,
  input logic [XLEN-1:0]  alu_res,
  input logic             br_taken,
  input logic [XLEN-1:0]  target,
  input logic [XLEN-1:0]  link,
  input logic             reg_we,
  input logic             mem_we,
  input logic             mem_re,
  input logic             illegal
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_quiet_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!reg_we && !mem_we && !mem_re && !br_taken && iclass == 3'd0));

  p_store_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!reg_we && !mem_re && iclass == 3'd4));

  p_taken_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> iclass == 3'd5);

  p_addr_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (iclass == 3'd3 || iclass == 3'd4)) |-> alu_res == $past(op_a) + imm);

  p_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> link == $past(pc) + 32'd4);

  p_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> target == $past(pc) + imm);

  p_even_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iclass == 3'd5 || iclass == 3'd6) |-> imm[0] == 1'b0);

  p_signed_lt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && iclass == 3'd5 && $past(instr[14:12]) == 3'b100)
      |-> br_taken == ($signed($past(op_a)) < $signed($past(op_b))));

  p_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (rs1_idx == $past(instr[19:15]) && rs2_idx == $past(instr[24:20])
                 && rd_idx == $past(instr[11:7])));
endmodule

bind insn_exec_unit insn_exec_chk u_chk (.*);

// File: tb/insn_exec_unit_bench.sv
module insn_exec_unit_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0, pc = '0, op_a = '0, op_b = '0;
  logic [4:0]  rs1_idx, rs2_idx, rd_idx;
  logic [31:0] imm, alu_res, target, link;
  logic [2:0]  iclass;
  logic        br_taken, reg_we, mem_we, mem_re, illegal;

  int checks = 0;
  int failures = 0;
  logic [31:0] rng = 32'h1234_5679;

  always #(CLK_P/2) clk = ~clk;

  insn_exec_unit u_insn_exec_unit (.*);

  typedef struct packed {
    logic [2:0]  cls;
    logic [31:0] imm, alu, tgt, lnk;
    logic        tk, rwe, mwe, mre, ill;
  } exp_t;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [31:0] p,
                                 input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    logic ok;
    logic [31:0] ii, is, ib, ij;
    logic [12:0] braw;
    logic [20:0] jraw;
    ii = 32'($signed(w) >>> 20);
    is = (32'($signed(w) >>> 25) << 5) | {27'd0, w[11:7]};
    braw = {w[31], w[7], w[30:25], w[11:8], 1'b0};
    ib = 32'($signed({braw, 19'd0}) >>> 19);
    jraw = {w[31], w[19:12], w[20], w[30:21], 1'b0};
    ij = 32'($signed({jraw, 11'd0}) >>> 11);
    e = '0;
    ok = 1'b0;
    case (w[6:0])
      7'h33: begin
        e.cls = 3'd1; e.rwe = 1'b1;
        if (w[14:12] == 3'd0 && w[31:25] == 7'h00) begin ok = 1; e.alu = a + b; end
        else if (w[14:12] == 3'd0 && w[31:25] == 7'h20) begin ok = 1; e.alu = a - b; end
        else if (w[31:25] == 7'h00) begin
          if (w[14:12] == 3'd4) begin ok = 1; e.alu = a ^ b; end
          if (w[14:12] == 3'd6) begin ok = 1; e.alu = a | b; end
          if (w[14:12] == 3'd7) begin ok = 1; e.alu = a & b; end
        end
      end
      7'h13: begin
        e.cls = 3'd2; e.rwe = 1'b1; e.imm = ii;
        if (w[14:12] == 3'd0) begin ok = 1; e.alu = a + ii; end
        if (w[14:12] == 3'd4) begin ok = 1; e.alu = a ^ ii; end
        if (w[14:12] == 3'd6) begin ok = 1; e.alu = a | ii; end
        if (w[14:12] == 3'd7) begin ok = 1; e.alu = a & ii; end
      end
      7'h03: begin
        e.cls = 3'd3; e.rwe = 1'b1; e.mre = 1'b1; e.imm = ii; e.alu = a + ii;
        ok = (w[14:12] == 3'd2);
      end
      7'h23: begin
        e.cls = 3'd4; e.mwe = 1'b1; e.imm = is; e.alu = a + is;
        ok = (w[14:12] == 3'd2);
      end
      7'h63: begin
        e.cls = 3'd5; e.imm = ib; e.alu = a - b;
        if (w[14:12] == 3'd0) begin ok = 1; e.tk = (a == b); end
        if (w[14:12] == 3'd1) begin ok = 1; e.tk = (a != b); end
        if (w[14:12] == 3'd4) begin ok = 1; e.tk = ($signed(a) < $signed(b)); end
        if (w[14:12] == 3'd5) begin ok = 1; e.tk = !($signed(a) < $signed(b)); end
      end
      7'h6f: begin
        e.cls = 3'd6; e.rwe = 1'b1; e.imm = ij; e.alu = p + 32'd4; ok = 1;
      end
      default: ok = 1'b0;
    endcase
    if (!ok) begin
      e = '0;
      e.ill = 1'b1;
    end
    e.lnk = p + 32'd4;
    e.tgt = p + e.imm;
    return e;
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s instr=%h actual=%h expected=%h", req, instr, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [31:0] p,
                     input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    string t;
    @(negedge clk);
    instr = w; pc = p; op_a = a; op_b = b;
    e = model(w, p, a, b);
    @(negedge clk);
    t = tag_of(e.cls);
    chk(t, {iclass, imm, alu_res, reg_we, mem_we, mem_re, illegal},
           {e.cls, e.imm, e.alu, e.rwe, e.mwe, e.mre, e.ill});
    chk((e.cls == 3'd5 && w[14]) ? "R7" : "R6", 128'(br_taken), 128'(e.tk));
    chk(e.cls == 3'd6 ? "R9" : "R8", {target, link}, {e.tgt, e.lnk});
    chk("R11", {rs1_idx, rs2_idx, rd_idx}, {w[19:15], w[24:20], w[11:7]});
  endtask

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] r2,
                                      input logic [4:0] r1, input logic [2:0] f3,
                                      input logic [4:0] rd, input logic [6:0] op);
    return {f7, r2, r1, f3, rd, op};
  endfunction

  initial begin
    #(CLK_P * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] pairs_a [6];
    logic [31:0] pairs_b [6];
    logic [6:0]  f7s [4];
    logic [31:0] ipat [4];
    pairs_a = '{32'd5, 32'hffff_ffff, 32'd1, 32'h8000_0000, 32'h7fff_ffff, 32'd0};
    pairs_b = '{32'd5, 32'd1, 32'hffff_ffff, 32'h7fff_ffff, 32'h8000_0000, 32'd7};
    f7s = '{7'h00, 7'h20, 7'h01, 7'h7f};
    ipat = '{32'hffff_ff80, 32'h8000_0000, 32'h0000_0080, 32'h7fff_f000};

    instr = 32'hffff_ffff; pc = 32'h1234; op_a = 32'h55; op_b = 32'haa;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    chk("R1", {rs1_idx, rs2_idx, rd_idx, imm, iclass, alu_res, br_taken},
              128'd0);
    chk("R1", {target, link, reg_we, mem_we, mem_re, illegal}, 128'd0);
    rst_n = 1'b1;

    // exhaustive opcode x funct3 x funct7 sweep (R2..R5, R9, R10)
    for (int op = 0; op < 128; op++)
      for (int f3 = 0; f3 < 8; f3++)
        for (int k = 0; k < 4; k++) begin
          logic [31:0] w;
          rng = nxt(rng);
          w = enc(f7s[k], rng[4:0], rng[9:5], 3'(f3), rng[14:10], 7'(op));
          rng = nxt(rng);
          run(w, {rng[31:2], 2'b00}, nxt(rng), nxt(nxt(rng)));
        end

    // R6 R7: branch compares across the sign boundary
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 6; i++)
        run(enc(7'h3f, 5'd2, 5'd1, 3'(f), 5'd9, 7'h63), 32'h0000_1000,
            pairs_a[i], pairs_b[i]);

    // R8 R9 R3 R5: immediate bit scattering with sparse/dense patterns
    for (int i = 0; i < 4; i++) begin
      run(ipat[i] | 32'h0000_0063, 32'h0000_2000, 32'd3, 32'd3);
      run(ipat[i] | 32'h0000_006f, 32'hffff_fff0, 32'd0, 32'd0);
      run(ipat[i] | 32'h0000_0013, 32'h0, 32'h1000, 32'd0);
      run(ipat[i] | 32'h0000_2023, 32'h0, 32'h1000, 32'd0);
      run(ipat[i] | 32'h0000_2003, 32'h0, 32'hffff_fffc, 32'd0);
    end

    // R2: subtract wraps below zero
    run(enc(7'h20, 5'd3, 5'd4, 3'd0, 5'd5, 7'h33), 32'd0, 32'd1, 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule